// File: doc/BRIEF.md
# Pipelined Binary Decision Tree Classifier

This block evaluates one configurable binary decision tree of fixed depth on a stream of feature vectors, one vector per clock. Each vector is a packed bus of attributes, each an unsigned word; the attribute count is six per texture displacement plus two color attributes. It is intended as the weak-classifier building block of a boosted ensemble. A surrounding module instantiates many copies, feeds each its own static configuration, and weights and sums the leaf decisions.

Every internal node of the tree has two configuration fields: an attribute-select code that names the attribute it tests, and an unsigned threshold. Every leaf has a 2-bit signed result. A selection stage first routes an attribute to every node. Then each depth level has a multiplexing stage and a comparison stage. The multiplexing stage uses the branch bits resolved so far to pick the one node on the active path, along with its attribute and threshold. The comparison stage appends one branch bit to the path. A last stage turns the finished path into the leaf result. The latency is fixed at twelve clocks, and a valid flag travels with the data.

The configuration buses must be held steady while vectors are in flight. `rst_n` is asynchronous and active low, and it must be deasserted synchronously to `clk`.

Top module: `dtree_pipe`

## Requirements
- R1: Attribute k is taken from `in_feat[k*NB +: NB]`. Internal node n uses the select code `node_attr_sel[n*SELW +: SELW]` and the threshold `node_thresh[n*NB +: NB]`. Nodes are numbered breadth first: the root is 0, and the children of node n are 2n+1 on the left and 2n+2 on the right.
- R2: A node takes the right branch only when its attribute is strictly greater than its threshold, both compared as unsigned values. When the two are equal, the node takes the left branch.
- R3: The leaf index is the sequence of branch bits, with right = 1 and the root's decision as the most significant bit. Leaf i therefore sits under node 31+i, and its result field is `leaf_sign[i*2 +: 2]`.
- R4: A select code of NF or above reads as an attribute value of zero, so that node always goes left.
- R5: A vector presented with `in_valid` high in cycle t produces `out_valid` high in cycle t+12. Vectors may arrive in consecutive cycles or with gaps, and `out_valid` reproduces the input valid pattern delayed by twelve cycles.
- R6: Reset clears every valid stage and sets `out_decision` to 0. Vectors that are in flight when reset is asserted never produce an `out_valid` pulse.
- R7: In a cycle where `out_valid` is low, `out_decision` keeps the last result it issued.
- R8: `out_decision` is the selected leaf field copied bit for bit. The encoding 2'b01 means +1 and 2'b11 means -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| in_valid | input | 1 | A feature vector is present this cycle |
| in_feat | input | NF*NB (112) | Packed attribute vector |
| node_attr_sel | input | NNODE*SELW (124) | Per-node attribute select codes |
| node_thresh | input | NNODE*NB (248) | Per-node unsigned thresholds |
| leaf_sign | input | NLEAF*2 (64) | Per-leaf 2-bit signed results |
| out_valid | output | 1 | Result present this cycle |
| out_decision | output | 2 | Signed leaf decision |

## Verification
If one level's branch bit or node index is wrong, the vector is steered into the wrong subtree. The error appears as a wrong leaf field exactly twelve cycles after that vector entered, and only for vectors whose attribute lies on the affected side of a threshold. For this reason the stimulus walks all 32 leaves, places attributes exactly on and next to the thresholds, and changes which leaf field identifies which path bits. A delay line that is misaligned shows up as results that depend on the neighbouring vector in a back-to-back stream. Broken valid tracking shows up as a mismatch in the `out_valid` pattern within the same twelve cycles.

// File: rtl/dtree_pkg.sv
package dtree_pkg;

  // first breadth-first node index of a tree level
  function automatic int lvl_base(input int lvl);
    return (1 << lvl) - 1;
  endfunction

  // number of nodes on a tree level
  function automatic int lvl_count(input int lvl);
    return 1 << lvl;
  endfunction

endpackage

// File: rtl/dtree_attr_select.sv
module dtree_attr_select #(
  parameter int NF    = 14,
  parameter int NB    = 8,
  parameter int SELW  = 4,
  parameter int NNODE = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [NF*NB-1:0]      in_feat,
  input  logic [NNODE*SELW-1:0] node_attr_sel,
  output logic                  sel_valid,
  output logic [NNODE*NB-1:0]   sel_att
);

  logic [NNODE*NB-1:0] att_nxt;

  for (genvar n = 0; n < NNODE; n++) begin : g_node
    logic [NB-1:0] node_att;

    always_comb begin
      int code;
      code     = int'(node_attr_sel[n*SELW +: SELW]);
      node_att = '0;
      if (code < NF) node_att = in_feat[code*NB +: NB];
    end

    assign att_nxt[n*NB +: NB] = node_att;

    if (NF < (1 << SELW)) begin : g_oob_chk
      // R4: an out-of-range code delivers a zero attribute
      p_oob_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && (int'($past(node_attr_sel[n*SELW +: SELW])) >= NF))
        |-> (sel_att[n*NB +: NB] == '0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_valid <= 1'b0;
    else        sel_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) sel_att <= att_nxt;
  end

endmodule

// File: rtl/dtree_delay.sv
module dtree_delay #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [N];

  always_ff @(posedge clk) begin
    stg[0] <= din;
    for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
  end

  assign dout = stg[N-1];

endmodule

// File: rtl/dtree_level.sv
module dtree_level #(
  parameter int DEPTH = 5,
  parameter int LEVEL = 0,
  parameter int NB    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        v_in,
  input  logic [DEPTH-1:0]            path_in,
  input  logic [(1<<LEVEL)*NB-1:0]    att_lvl,
  input  logic [(1<<LEVEL)*NB-1:0]    thr_lvl,
  output logic                        v_out,
  output logic [DEPTH-1:0]            path_out
);

  localparam int BITPOS = DEPTH - 1 - LEVEL;
  localparam int HI_I   = ((1 << DEPTH) - 1) & ~((1 << (DEPTH - LEVEL)) - 1);
  localparam int LO_I   = (1 << BITPOS) - 1;

  // stage A: pick the node on the active path
  logic [NB-1:0]    att_m, thr_m;
  logic             va;
  logic [NB-1:0]    att_a, thr_a;
  logic [DEPTH-1:0] path_a;

  always_comb begin
    int idx;
    idx   = int'(path_in) >> (DEPTH - LEVEL);
    att_m = att_lvl[idx*NB +: NB];
    thr_m = thr_lvl[idx*NB +: NB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) va <= 1'b0;
    else        va <= v_in;
  end

  always_ff @(posedge clk) begin
    if (v_in) begin
      att_a  <= att_m;
      thr_a  <= thr_m;
      path_a <= path_in;
    end
  end

  // stage B: compare and append the branch bit
  logic [DEPTH-1:0] path_nxt;

  always_comb begin
    path_nxt         = path_a;
    path_nxt[BITPOS] = (att_a > thr_a);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_out <= 1'b0;
    else        v_out <= va;
  end

  always_ff @(posedge clk) begin
    if (va) path_out <= path_nxt;
  end

  // checker state: cycles since reset, saturating
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R5: valid moves exactly two cycles through a level
  p_valid_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (v_out == $past(v_in, 2)));

  // R2: strict unsigned greater-than steers right
  p_branch_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    v_out |-> (path_out[BITPOS] == ($past(att_a) > $past(thr_a))));

  // R3: earlier decisions keep their bits, later bits stay clear
  p_prefix_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v_out |-> (((path_out & DEPTH'(HI_I)) == ($past(path_in, 2) & DEPTH'(HI_I)))
               && ((path_out & DEPTH'(LO_I)) == '0)));

endmodule

// File: rtl/dtree_pipe.sv
module dtree_pipe
  import dtree_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int NDISP = 2,
  parameter int NB    = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  input  logic [(6*NDISP+2)*NB-1:0]             in_feat,
  input  logic [((1<<DEPTH)-1)*$clog2(6*NDISP+2)-1:0] node_attr_sel,
  input  logic [((1<<DEPTH)-1)*NB-1:0]          node_thresh,
  input  logic [(1<<DEPTH)*2-1:0]               leaf_sign,
  output logic                                  out_valid,
  output logic signed [1:0]                     out_decision
);

  localparam int NF    = 6 * NDISP + 2;
  localparam int SELW  = $clog2(NF);
  localparam int NNODE = (1 << DEPTH) - 1;

  logic                sel_valid;
  logic [NNODE*NB-1:0] sel_att;

  dtree_attr_select #(.NF(NF), .NB(NB), .SELW(SELW), .NNODE(NNODE)) u_sel (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_feat       (in_feat),
    .node_attr_sel (node_attr_sel),
    .sel_valid     (sel_valid),
    .sel_att       (sel_att)
  );

  logic             lvl_v    [DEPTH+1];
  logic [DEPTH-1:0] lvl_path [DEPTH+1];

  assign lvl_v[0]    = sel_valid;
  assign lvl_path[0] = '0;

  for (genvar L = 0; L < DEPTH; L++) begin : g_lvl
    localparam int BASE = lvl_base(L);
    localparam int CNT  = lvl_count(L);
    logic [CNT*NB-1:0] att_dly;

    if (L == 0) begin : g_direct
      assign att_dly = sel_att[BASE*NB +: CNT*NB];
    end else begin : g_dly
      dtree_delay #(.W(CNT*NB), .N(2*L)) u_dly (
        .clk  (clk),
        .din  (sel_att[BASE*NB +: CNT*NB]),
        .dout (att_dly)
      );
    end

    dtree_level #(.DEPTH(DEPTH), .LEVEL(L), .NB(NB)) u_lvl (
      .clk      (clk),
      .rst_n    (rst_n),
      .v_in     (lvl_v[L]),
      .path_in  (lvl_path[L]),
      .att_lvl  (att_dly),
      .thr_lvl  (node_thresh[BASE*NB +: CNT*NB]),
      .v_out    (lvl_v[L+1]),
      .path_out (lvl_path[L+1])
    );
  end

  // leaf stage
  logic [1:0] dec_nxt;

  always_comb begin
    dec_nxt = leaf_sign[int'(lvl_path[DEPTH])*2 +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_decision <= '0;
    end else begin
      out_valid <= lvl_v[DEPTH];
      if (lvl_v[DEPTH]) out_decision <= dec_nxt;
    end
  end

  // R7: no new result, no change on the decision output
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_v[DEPTH] |=> $stable(out_decision));

endmodule

// File: tb/tb_dtree_pipe.sv
`timescale 1ns/1ps
module tb_dtree_pipe;

  localparam int DEPTH = 5;
  localparam int NB    = 8;
  localparam int NF    = 14;
  localparam int SELW  = 4;
  localparam int NNODE = 31;
  localparam int NLEAF = 32;
  localparam int FW    = NF * NB;
  localparam int LAT   = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [FW-1:0]          in_feat;
  logic [NNODE*SELW-1:0]  cfg_j;
  logic [NNODE*NB-1:0]    cfg_c;
  logic [NLEAF*2-1:0]     cfg_l;
  logic                   out_valid;
  logic signed [1:0]      out_decision;

  always #2 clk = ~clk;

  dtree_pipe dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_feat       (in_feat),
    .node_attr_sel (cfg_j),
    .node_thresh   (cfg_c),
    .leaf_sign     (cfg_l),
    .out_valid     (out_valid),
    .out_decision  (out_decision)
  );

  int checks = 0;
  int errors = 0;
  logic [1:0] hold_exp;
  bit [31:0] rs = 32'h1234_5678;

  logic [FW-1:0] vf [64];
  bit            vv [64];

  function automatic bit [31:0] rnd();
    rs ^= rs << 13;
    rs ^= rs >> 17;
    rs ^= rs << 5;
    return rs;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int node_lvl(input int n);
    int l = 0;
    while (((1 << (l + 1)) - 1) <= n) l++;
    return l;
  endfunction

  // tree walk from the requirements
  function automatic logic [1:0] ref_leaf(input logic [FW-1:0] f);
    int n = 0;
    for (int d = 0; d < DEPTH; d++) begin
      int k = int'(cfg_j[n*SELW +: SELW]);
      int a = (k < NF) ? int'(f[k*NB +: NB]) : 0;
      int t = int'(cfg_c[n*NB +: NB]);
      n = 2 * n + 1 + ((a > t) ? 1 : 0);
    end
    return cfg_l[(n - NNODE)*2 +: 2];
  endfunction

  function automatic logic [FW-1:0] rnd_feat();
    logic [FW-1:0] f;
    for (int k = 0; k < NF; k++) f[k*NB +: NB] = rnd()[NB-1:0];
    return f;
  endfunction

  task automatic rnd_config();
    for (int n = 0; n < NNODE; n++) begin
      cfg_j[n*SELW +: SELW] = SELW'(rnd() % NF);
      cfg_c[n*NB +: NB]     = rnd()[NB-1:0];
    end
    for (int i = 0; i < NLEAF; i++) cfg_l[i*2 +: 2] = rnd()[0] ? 2'b11 : 2'b01;
  endtask

  // drive vf/vv for n cycles and check every output cycle
  task automatic run_stream(input int n, input string tag);
    for (int c = 0; c < n + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        int i = c - LAT;
        check(out_valid == vv[i], "R5 valid", int'(out_valid), int'(vv[i]));
        if (vv[i]) hold_exp = ref_leaf(vf[i]);
        check(out_decision == hold_exp, vv[i] ? tag : "R7 hold",
              int'(out_decision), int'(hold_exp));
      end else begin
        check(out_valid == 1'b0, "R5 idle", int'(out_valid), 0);
      end
      if (c < n) begin
        in_valid = vv[c];
        in_feat  = vf[c];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_feat = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R6 reset valid", int'(out_valid), 0);
    check(out_decision == 2'b00, "R6 reset decision", int'(out_decision), 0);
    rst_n = 1'b1;
    hold_exp = 2'b00;
  endtask

  task automatic t_random();
    rnd_config();
    for (int i = 0; i < 40; i++) begin vf[i] = rnd_feat(); vv[i] = 1'b1; end
    run_stream(40, "R1 random back-to-back");
  endtask

  task automatic t_equal();
    for (int n = 0; n < NNODE; n++) begin
      cfg_j[n*SELW +: SELW] = 4'd3;
      cfg_c[n*NB +: NB]     = 8'd100;
    end
    for (int i = 0; i < NLEAF; i++) cfg_l[i*2 +: 2] = 2'b10;
    cfg_l[0 +: 2]  = 2'b01;
    cfg_l[62 +: 2] = 2'b11;
    for (int i = 0; i < 6; i++) begin vf[i] = rnd_feat(); vv[i] = 1'b1; end
    vf[0][3*NB +: NB] = 8'd100;  // equal: left everywhere, leaf 0 -> 01
    vf[1][3*NB +: NB] = 8'd101;  // above: right everywhere, leaf 31 -> 11
    vf[2][3*NB +: NB] = 8'd99;
    vf[3][3*NB +: NB] = 8'd255;
    vf[4][3*NB +: NB] = 8'd0;
    vf[5][3*NB +: NB] = 8'd100;
    run_stream(6, "R2 threshold boundary");
  endtask

  task automatic t_path(input int pass);
    for (int n = 0; n < NNODE; n++) begin
      cfg_j[n*SELW +: SELW] = SELW'(node_lvl(n));
      cfg_c[n*NB +: NB]     = 8'd127;
    end
    for (int i = 0; i < NLEAF; i++) begin
      logic [4:0] li = 5'(i);
      case (pass)
        0:       cfg_l[i*2 +: 2] = li[1:0];
        1:       cfg_l[i*2 +: 2] = li[3:2];
        default: cfg_l[i*2 +: 2] = {1'b0, li[4]};
      endcase
    end
    for (int p = 0; p < NLEAF; p++) begin
      vf[p] = rnd_feat();
      for (int d = 0; d < DEPTH; d++)
        vf[p][d*NB +: NB] = ((p >> (DEPTH - 1 - d)) & 1) ? 8'd128 : 8'd127;
      vv[p] = 1'b1;
    end
    run_stream(NLEAF, "R3 R8 leaf path order");
  endtask

  task automatic t_oob();
    for (int n = 0; n < NNODE; n++) begin
      cfg_j[n*SELW +: SELW] = (n % 2 == 0) ? 4'd15 : 4'd14;
      cfg_c[n*NB +: NB]     = 8'd0;
    end
    for (int i = 0; i < NLEAF; i++) cfg_l[i*2 +: 2] = 2'b11;
    cfg_l[0 +: 2] = 2'b01;
    for (int i = 0; i < 4; i++) begin vf[i] = '1; vv[i] = 1'b1; end
    run_stream(4, "R4 out-of-range select");
    // contrast: a legal top code on the same data steers right
    for (int n = 0; n < NNODE; n++) cfg_j[n*SELW +: SELW] = 4'd13;
    run_stream(2, "R4 legal top code");
  endtask

  task automatic t_gaps();
    rnd_config();
    for (int i = 0; i < 48; i++) begin
      vf[i] = rnd_feat();
      vv[i] = (i % 3 != 1) && (i % 7 != 5);
    end
    run_stream(48, "R7 gapped stream");
  endtask

  task automatic t_reset_mid();
    rnd_config();
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_feat  = rnd_feat();
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    hold_exp = 2'b00;
    for (int c = 0; c < LAT + 2; c++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R6 flushed valid", int'(out_valid), 0);
      check(out_decision == 2'b00, "R6 flushed decision", int'(out_decision), 0);
    end
  endtask

  bit finished = 1'b0;

  initial begin
    cfg_j = '0; cfg_c = '0; cfg_l = '0;
    t_reset();
    t_random();
    t_equal();
    for (int p = 0; p < 3; p++) t_path(p);
    t_oob();
    t_gaps();
    t_reset_mid();
    t_random();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule